// File: doc/BRIEF.md
# Asynchronous FIFO Peripheral Bus Master

This block masters an external FIFO peripheral over an 8-bit parallel data bus. The peripheral has no clock input, so every transfer is shaped as strobe waveforms that the block generates from its own clock. A transfer is launched with a one-cycle start pulse, a direction bit and a byte count from 1 to 512. The block then moves bytes one at a time. Reads go from the peripheral into a received-byte output. Writes go from the head of an internal buffer onto the bus. The internal buffer is outside this block and is advanced by a pop pulse.

Each byte is gated by a ready flag from the peripheral: not-empty for reads and not-full for writes. Both flags are asynchronous and pass through a two-flop synchronizer before use. If the flag is low at the check before a byte, the transfer stops with a one-cycle abort pulse instead of waiting. A write that finishes with fewer than 512 bytes is closed by a single low pulse on the packet-end strobe, so that the peripheral commits the partial packet. All strobes towards the peripheral are active low.

Top module: `afifo_bus_master`

## Requirements
- R1: After reset and whenever the block is idle, `done_o` is 1, the read, write, output-enable and packet-end strobes are all high, and the data drive enable is 0. `done_o` is 0 from the cycle after an accepted start until the transfer ends.
- R2: For a read (`dir_i`=0), the synchronized not-empty flag is tested before each byte. The read strobe then stays low for exactly 3 cycles, with the output-enable strobe low. The bus byte present in the last strobe cycle appears on `rx_data_o`, with `rx_valid_o` high for one cycle in the cycle after the strobe rises.
- R3: For a write (`dir_i`=1), the synchronized not-full flag is tested before each byte. The byte at `tx_data_i` is then taken and `tx_pop_o` pulses once. The byte is driven with `per_drive_o` high while the write strobe stays low for exactly 3 cycles. The byte and the drive enable are held for one further cycle after the strobe rises.
- R4: The FIFO address lines read 2'b00 during a read and 2'b10 during a write (bit 1 high, bit 0 low).
- R5: A transfer that is not aborted moves exactly `count_i` bytes. It then returns to idle with `xfer_done_o` high for exactly one cycle, the first idle cycle.
- R6: If the ready flag is low at a byte check, no further strobe is issued. `abort_o` is high for one cycle, the block then returns to idle, and `xfer_done_o` does not pulse.
- R7: A completed write with a count below 512 is followed by exactly one cycle with the packet-end strobe low, before `xfer_done_o`. Full 512-byte writes, reads and aborted transfers never pulse packet-end.
- R8: A start pulse while `done_o` is 0 is ignored: the running transfer continues with the same direction, address and count. `start_err_o` is high for one cycle in the cycle after that start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (48 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer launch pulse |
| dir_i | input | 1 | 0 = read from peripheral, 1 = write to peripheral |
| count_i | input | 10 | Byte count, 1 to 512 |
| tx_data_i | input | 8 | Head byte of the internal transmit buffer |
| tx_pop_o | output | 1 | Advances the transmit buffer by one byte |
| rx_data_o | output | 8 | Byte received from the peripheral |
| rx_valid_o | output | 1 | One-cycle qualifier for `rx_data_o` |
| done_o | output | 1 | High while the block is idle |
| xfer_done_o | output | 1 | One-cycle pulse when a transfer completes |
| abort_o | output | 1 | One-cycle interrupt pulse when a ready flag stops a transfer |
| start_err_o | output | 1 | One-cycle pulse for a start received while busy |
| per_addr_o | output | 2 | FIFO select lines to the peripheral |
| per_rd_n_o | output | 1 | Read strobe, active low |
| per_wr_n_o | output | 1 | Write strobe, active low |
| per_oe_n_o | output | 1 | Peripheral output enable, active low |
| per_pktend_n_o | output | 1 | Packet commit strobe, active low |
| per_data_o | output | 8 | Write data towards the bus |
| per_drive_o | output | 1 | Enables this block's bus drivers |
| per_data_i | input | 8 | Read data from the bus |
| per_not_empty_i | input | 1 | Asynchronous peripheral flag: data available |
| per_not_full_i | input | 1 | Asynchronous peripheral flag: space available |

## Verification
The assertions assume three things about the inputs. First, `count_i` lies between 1 and 512 whenever a start is accepted. Second, `tx_data_i` holds a valid head byte whenever the block may take one. Third, the peripheral lowers a ready flag within one cycle of the strobe that exhausts it, so the synchronized copy is current by the next byte check. The bench's peripheral model meets all three. It updates its flags on the falling edge of each strobe and only loads its contents while the block is idle. The stimulus launches only legal counts, including the 1, 511 and 512 boundaries. It produces flag failures only through a shortage of stored bytes or free space in the model.

// File: rtl/afbm_pkg.sv
package afbm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_R_CHK  = 4'd1,
        ST_R_STB  = 4'd2,
        ST_R_HOLD = 4'd3,
        ST_W_CHK  = 4'd4,
        ST_W_STB  = 4'd5,
        ST_W_HOLD = 4'd6,
        ST_PKTEND = 4'd7,
        ST_ABORT  = 4'd8
    } fsm_st_e;

    localparam logic [1:0] SEL_RD = 2'b00;
    localparam logic [1:0] SEL_WR = 2'b10;

endpackage

// File: rtl/afbm_sync.sv
module afbm_sync #(
    parameter int NBITS  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] async_i,
    output logic [NBITS-1:0] sync_o
);
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/afbm_xfer_cnt.sv
module afbm_xfer_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/afbm_fsm.sv
module afbm_fsm
    import afbm_pkg::*;
#(
    parameter int MAX_PKT = 512,
    parameter int STB_CYC = 3,
    parameter int CNT_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [7:0]       tx_data_i,
    input  logic [7:0]       per_data_i,
    input  logic             ne_i,
    input  logic             nf_i,
    input  logic             cnt_zero_i,
    output logic             cnt_load_o,
    output logic             cnt_dec_o,
    output logic             tx_pop_o,
    output logic [7:0]       rx_data_o,
    output logic             rx_valid_o,
    output logic             done_o,
    output logic             xfer_done_o,
    output logic             abort_o,
    output logic             start_err_o,
    output logic [1:0]       per_addr_o,
    output logic             per_rd_n_o,
    output logic             per_wr_n_o,
    output logic             per_oe_n_o,
    output logic             per_pktend_n_o,
    output logic [7:0]       per_data_o,
    output logic             per_drive_o
);
    localparam int WAIT_W = $clog2(STB_CYC + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(STB_CYC - 1);

    typedef struct packed {
        fsm_st_e           st;
        logic [WAIT_W-1:0] wt;
        logic              short_pkt;
        logic [1:0]        addr;
        logic              rd_n;
        logic              wr_n;
        logic              oe_n;
        logic              pkt_n;
        logic              drive;
        logic              done;
        logic              abort;
        logic              xdone;
        logic              serr;
        logic              rx_valid;
        logic              tx_pop;
        logic [7:0]        dout;
        logic [7:0]        rx_data;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, wt: '0, short_pkt: 1'b0, addr: SEL_RD,
        rd_n: 1'b1, wr_n: 1'b1, oe_n: 1'b1, pkt_n: 1'b1, drive: 1'b0,
        done: 1'b1, abort: 1'b0, xdone: 1'b0, serr: 1'b0,
        rx_valid: 1'b0, tx_pop: 1'b0, dout: '0, rx_data: '0
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rx_valid = 1'b0;
        r_d.tx_pop = 1'b0;
        r_d.xdone  = 1'b0;
        r_d.serr   = 1'b0;
        cnt_load_o = 1'b0;
        cnt_dec_o  = 1'b0;

        if (start_i && (r_q.st != ST_IDLE)) begin
            r_d.serr = 1'b1;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    cnt_load_o    = 1'b1;
                    r_d.short_pkt = (count_i < CNT_W'(MAX_PKT));
                    if (dir_i) begin
                        r_d.st   = ST_W_CHK;
                        r_d.addr = SEL_WR;
                    end else begin
                        r_d.st   = ST_R_CHK;
                        r_d.addr = SEL_RD;
                    end
                end
            end
            ST_R_CHK: begin
                r_d.wt = '0;
                r_d.st = ne_i ? ST_R_STB : ST_ABORT;
            end
            ST_R_STB: begin
                if (r_q.wt == WAIT_LAST) begin
                    r_d.rx_data  = per_data_i;
                    r_d.rx_valid = 1'b1;
                    cnt_dec_o    = 1'b1;
                    r_d.st       = ST_R_HOLD;
                end else begin
                    r_d.wt = r_q.wt + WAIT_W'(1);
                end
            end
            ST_R_HOLD: begin
                r_d.st    = cnt_zero_i ? ST_IDLE : ST_R_CHK;
                r_d.xdone = cnt_zero_i;
            end
            ST_W_CHK: begin
                r_d.wt = '0;
                if (nf_i) begin
                    r_d.st     = ST_W_STB;
                    r_d.dout   = tx_data_i;
                    r_d.tx_pop = 1'b1;
                end else begin
                    r_d.st = ST_ABORT;
                end
            end
            ST_W_STB: begin
                if (r_q.wt == WAIT_LAST) begin
                    cnt_dec_o = 1'b1;
                    r_d.st    = ST_W_HOLD;
                end else begin
                    r_d.wt = r_q.wt + WAIT_W'(1);
                end
            end
            ST_W_HOLD: begin
                if (!cnt_zero_i) begin
                    r_d.st = ST_W_CHK;
                end else if (r_q.short_pkt) begin
                    r_d.st = ST_PKTEND;
                end else begin
                    r_d.st    = ST_IDLE;
                    r_d.xdone = 1'b1;
                end
            end
            ST_PKTEND: begin
                r_d.st    = ST_IDLE;
                r_d.xdone = 1'b1;
            end
            ST_ABORT: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        r_d.rd_n  = (r_d.st != ST_R_STB);
        r_d.oe_n  = !((r_d.st == ST_R_STB) || (r_d.st == ST_R_HOLD));
        r_d.wr_n  = (r_d.st != ST_W_STB);
        r_d.drive = (r_d.st == ST_W_STB) || (r_d.st == ST_W_HOLD);
        r_d.pkt_n = (r_d.st != ST_PKTEND);
        r_d.done  = (r_d.st == ST_IDLE);
        r_d.abort = (r_d.st == ST_ABORT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign tx_pop_o       = r_q.tx_pop;
    assign rx_data_o      = r_q.rx_data;
    assign rx_valid_o     = r_q.rx_valid;
    assign done_o         = r_q.done;
    assign xfer_done_o    = r_q.xdone;
    assign abort_o        = r_q.abort;
    assign start_err_o    = r_q.serr;
    assign per_addr_o     = r_q.addr;
    assign per_rd_n_o     = r_q.rd_n;
    assign per_wr_n_o     = r_q.wr_n;
    assign per_oe_n_o     = r_q.oe_n;
    assign per_pktend_n_o = r_q.pkt_n;
    assign per_data_o     = r_q.dout;
    assign per_drive_o    = r_q.drive;
endmodule

// File: rtl/afifo_bus_master.sv
module afifo_bus_master #(
    parameter int MAX_PKT     = 512,
    parameter int STB_CYC     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [7:0]       tx_data_i,
    output logic             tx_pop_o,
    output logic [7:0]       rx_data_o,
    output logic             rx_valid_o,
    output logic             done_o,
    output logic             xfer_done_o,
    output logic             abort_o,
    output logic             start_err_o,
    output logic [1:0]       per_addr_o,
    output logic             per_rd_n_o,
    output logic             per_wr_n_o,
    output logic             per_oe_n_o,
    output logic             per_pktend_n_o,
    output logic [7:0]       per_data_o,
    output logic             per_drive_o,
    input  logic [7:0]       per_data_i,
    input  logic             per_not_empty_i,
    input  logic             per_not_full_i
);
    localparam int NFLAGS = 2;

    logic [NFLAGS-1:0] flags_sync;
    logic              cnt_load, cnt_dec, cnt_zero;

    afbm_sync #(
        .NBITS  (NFLAGS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({per_not_full_i, per_not_empty_i}),
        .sync_o  (flags_sync)
    );

    afbm_xfer_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (count_i),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    afbm_fsm #(
        .MAX_PKT (MAX_PKT),
        .STB_CYC (STB_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .dir_i          (dir_i),
        .count_i        (count_i),
        .tx_data_i      (tx_data_i),
        .per_data_i     (per_data_i),
        .ne_i           (flags_sync[0]),
        .nf_i           (flags_sync[1]),
        .cnt_zero_i     (cnt_zero),
        .cnt_load_o     (cnt_load),
        .cnt_dec_o      (cnt_dec),
        .tx_pop_o       (tx_pop_o),
        .rx_data_o      (rx_data_o),
        .rx_valid_o     (rx_valid_o),
        .done_o         (done_o),
        .xfer_done_o    (xfer_done_o),
        .abort_o        (abort_o),
        .start_err_o    (start_err_o),
        .per_addr_o     (per_addr_o),
        .per_rd_n_o     (per_rd_n_o),
        .per_wr_n_o     (per_wr_n_o),
        .per_oe_n_o     (per_oe_n_o),
        .per_pktend_n_o (per_pktend_n_o),
        .per_data_o     (per_data_o),
        .per_drive_o    (per_drive_o)
    );
endmodule

// File: rtl/afbm_checker.sv
module afbm_checker #(
    parameter int STB_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid_o,
    input logic       done_o,
    input logic       xfer_done_o,
    input logic       abort_o,
    input logic       start_err_o,
    input logic [1:0] per_addr_o,
    input logic       per_rd_n_o,
    input logic       per_wr_n_o,
    input logic       per_oe_n_o,
    input logic       per_pktend_n_o,
    input logic [7:0] per_data_o,
    input logic       per_drive_o
);
    logic [7:0] rd_lo_q, wr_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_lo_q <= '0;
            wr_lo_q <= '0;
        end else begin
            rd_lo_q <= per_rd_n_o ? 8'd0 : rd_lo_q + 8'd1;
            wr_lo_q <= per_wr_n_o ? 8'd0 : wr_lo_q + 8'd1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (per_rd_n_o && per_wr_n_o && per_pktend_n_o && !per_drive_o));

    a_r2_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_rd_n_o) |-> (rd_lo_q == 8'(STB_CYC)));

    a_r2_oe_with_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !per_rd_n_o |-> !per_oe_n_o);

    a_r2_rx_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $rose(per_rd_n_o));

    a_r3_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_wr_n_o) |-> (wr_lo_q == 8'(STB_CYC)));

    a_r3_drive_during_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr_n_o |-> (per_drive_o && per_oe_n_o && per_rd_n_o));

    a_r3_hold_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_wr_n_o) |-> (per_drive_o && $stable(per_data_o)));

    a_r4_rd_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !per_rd_n_o |-> (per_addr_o == 2'b00));

    a_r4_wr_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr_n_o |-> (per_addr_o == 2'b10));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |-> done_o ##1 !xfer_done_o);

    a_r6_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!abort_o && done_o && !xfer_done_o));

    a_r7_pktend_single: assert property (@(posedge clk) disable iff (!rst_n)
        !per_pktend_n_o |=> (per_pktend_n_o && xfer_done_o));

    a_r8_err_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |-> !$past(done_o));
endmodule

bind afifo_bus_master afbm_checker #(.STB_CYC(STB_CYC)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid_o     (rx_valid_o),
    .done_o         (done_o),
    .xfer_done_o    (xfer_done_o),
    .abort_o        (abort_o),
    .start_err_o    (start_err_o),
    .per_addr_o     (per_addr_o),
    .per_rd_n_o     (per_rd_n_o),
    .per_wr_n_o     (per_wr_n_o),
    .per_oe_n_o     (per_oe_n_o),
    .per_pktend_n_o (per_pktend_n_o),
    .per_data_o     (per_data_o),
    .per_drive_o    (per_drive_o)
);

// File: tb/afifo_bus_master_tb_top.sv
`timescale 1ns/1ps
module afifo_bus_master_tb_top;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             dir_i = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic [7:0]       tx_data_i;
    logic             tx_pop_o;
    logic [7:0]       rx_data_o;
    logic             rx_valid_o, done_o, xfer_done_o, abort_o, start_err_o;
    logic [1:0]       per_addr_o;
    logic             per_rd_n_o, per_wr_n_o, per_oe_n_o, per_pktend_n_o;
    logic [7:0]       per_data_o;
    logic             per_drive_o;
    logic [7:0]       per_data_i = '0;
    logic             per_not_empty_i, per_not_full_i;

    always #2.5 clk = ~clk;

    afifo_bus_master dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // peripheral model and transmit buffer
    logic [7:0] per_mem [1024];
    logic [7:0] tx_mem  [1024];
    int rd_ptr = 0, rd_cnt = 0, wr_free = 0, tx_idx = 0;
    logic [7:0] exp_rd_q [$];
    logic [7:0] exp_wr_q [$];
    int n_xdone = 0, n_abort = 0, n_pkt = 0, n_serr = 0;
    int n_rx = 0, n_wr = 0, w_bad = 0, a_bad = 0, rd_lo = 0, wr_lo = 0;

    assign per_not_empty_i = (rd_cnt != 0);
    assign per_not_full_i  = (wr_free != 0);
    assign tx_data_i       = tx_mem[tx_idx];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 53 + i * 29 + (i >> 3)) ^ (i * 7));
    endfunction

    always @(negedge per_rd_n_o) if (rst_n) begin
        per_data_i = per_mem[rd_ptr];
        rd_ptr++;
        if (rd_cnt > 0) rd_cnt--;
    end

    always @(negedge per_wr_n_o) if (rst_n) begin
        if (wr_free > 0) wr_free--;
    end

    // write-side monitor: compare bytes the peripheral captures (R3)
    always @(posedge per_wr_n_o) if (rst_n) begin
        n_wr++;
        chk(per_drive_o == 1'b1, "R3 drive held after strobe", int'(per_drive_o), 1);
        if (exp_wr_q.size() == 0) chk(1'b0, "R3 unexpected write byte", int'(per_data_o), -1);
        else begin
            logic [7:0] e;
            e = exp_wr_q.pop_front();
            chk(per_data_o == e, "R3 write byte", int'(per_data_o), int'(e));
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_pop_o) tx_idx++;
            n_xdone += int'(xfer_done_o);
            n_abort += int'(abort_o);
            n_pkt   += int'(!per_pktend_n_o);
            n_serr  += int'(start_err_o);
            if (!per_rd_n_o && (per_addr_o != 2'b00 || per_oe_n_o)) a_bad++;
            if (!per_wr_n_o && (per_addr_o != 2'b10 || !per_oe_n_o)) a_bad++;
            if (!per_rd_n_o) rd_lo++;
            else if (rd_lo != 0) begin
                if (rd_lo != 3) w_bad++;
                rd_lo = 0;
            end
            if (!per_wr_n_o) wr_lo++;
            else if (wr_lo != 0) begin
                if (wr_lo != 3) w_bad++;
                wr_lo = 0;
            end
            // read-side monitor (R2)
            if (rx_valid_o) begin
                n_rx++;
                if (exp_rd_q.size() == 0) chk(1'b0, "R2 unexpected rx byte", int'(rx_data_o), -1);
                else begin
                    logic [7:0] e;
                    e = exp_rd_q.pop_front();
                    chk(rx_data_o == e, "R2 rx byte", int'(rx_data_o), int'(e));
                end
            end
        end
    end

    task automatic run_xfer(input bit wr, input int cnt, input int avail,
                            input int seed, input bit poke);
        int moved;
        bit ab;
        int g;
        moved = (cnt < avail) ? cnt : avail;
        ab    = (avail < cnt);
        n_xdone = 0; n_abort = 0; n_pkt = 0; n_serr = 0;
        n_rx = 0; n_wr = 0; w_bad = 0; a_bad = 0;
        if (!wr) begin
            rd_ptr = 0;
            for (int i = 0; i < avail; i++) per_mem[i] = pat(seed, i);
            for (int i = 0; i < moved; i++) exp_rd_q.push_back(pat(seed, i));
            rd_cnt = avail;
        end else begin
            tx_idx = 0;
            for (int i = 0; i < cnt; i++) tx_mem[i] = pat(seed, i);
            for (int i = 0; i < moved; i++) exp_wr_q.push_back(pat(seed, i));
            wr_free = avail;
        end
        repeat (4) @(negedge clk);
        start_i = 1'b1; dir_i = wr; count_i = CNT_W'(cnt);
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R1 busy after start", int'(done_o), 0);
        if (poke) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1; dir_i = !wr; count_i = CNT_W'(1);
            @(negedge clk);
            start_i = 1'b0;
        end
        g = 0;
        while (!done_o && g < 20000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
        chk(done_o == 1'b1, "R1 idle after transfer", int'(done_o), 1);
        chk(n_abort == int'(ab), "R6 abort pulses", n_abort, int'(ab));
        chk(n_xdone == int'(!ab), "R5 done pulses", n_xdone, int'(!ab));
        chk(n_pkt == int'(wr && !ab && cnt < 512), "R7 packet-end pulses",
            n_pkt, int'(wr && !ab && cnt < 512));
        chk(n_serr == int'(poke), "R8 start error pulses", n_serr, int'(poke));
        chk(w_bad == 0, "R2 R3 strobe widths", w_bad, 0);
        chk(a_bad == 0, "R4 address or enable during strobe", a_bad, 0);
        if (!wr) begin
            chk(n_rx == moved, "R5 bytes read", n_rx, moved);
            chk(exp_rd_q.size() == 0, "R2 read scoreboard empty", exp_rd_q.size(), 0);
            chk(n_wr == 0, "R8 no write strobe in read", n_wr, 0);
        end else begin
            chk(n_wr == moved, "R5 bytes written", n_wr, moved);
            chk(tx_idx == moved, "R3 pops", tx_idx, moved);
            chk(exp_wr_q.size() == 0, "R3 write scoreboard empty", exp_wr_q.size(), 0);
            chk(n_rx == 0, "R8 no read in write", n_rx, 0);
        end
        exp_rd_q.delete();
        exp_wr_q.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(done_o == 1'b1, "R1 reset done", int'(done_o), 1);
        chk({per_rd_n_o, per_wr_n_o, per_oe_n_o, per_pktend_n_o} == 4'hF,
            "R1 reset strobes", int'({per_rd_n_o, per_wr_n_o, per_oe_n_o, per_pktend_n_o}), 15);
        chk(per_drive_o == 1'b0 && xfer_done_o == 1'b0, "R1 reset drive",
            int'(per_drive_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        run_xfer(1'b0, 5,   8,   1, 1'b0);
        run_xfer(1'b1, 7,   600, 2, 1'b0);
        run_xfer(1'b1, 512, 600, 3, 1'b0);
        run_xfer(1'b1, 511, 600, 4, 1'b0);
        run_xfer(1'b0, 3,   0,   5, 1'b0);
        run_xfer(1'b0, 10,  4,   6, 1'b0);
        run_xfer(1'b1, 6,   3,   7, 1'b0);
        run_xfer(1'b0, 6,   6,   8, 1'b1);
        run_xfer(1'b1, 6,   6,   9, 1'b1);
        run_xfer(1'b0, 1,   1,   10, 1'b0);
        run_xfer(1'b0, 512, 512, 11, 1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule